// File: doc/BRIEF.md
# Byte-Wide Flash Command Decoder and Write State Machine

This block models the control side of a byte-wide NOR flash part. The array is split into equal, separately erasable and lockable blocks, and it is held in an internal RAM. A host drives the asynchronous bus pins: chip enable, write enable, output enable, address and data. The block samples these pins on a system clock. Each write strobe hands one byte to the command decoder. Commands take one or two strobes. They start a byte program, a block erase, a suspend or a resume, a lock-bit change, a status clear, or a switch of what reads return.

Erase and program run as counted operations, so a simulation stays short. An erase sweeps the block one byte per cycle and writes FFh. A program waits a set number of cycles and then ANDs the new data into the old byte. A suspended erase can admit a byte program to another block, and that program can itself be suspended. A status byte reports ready, the two suspend states and sticky error flags. The `rdy` pin is high whenever no operation is running.

Top module: `flash_cui`

## Requirements
- R1: After the synchronous reset `rst`, the block is ready (`rdy`=1), reads return array data, no block or master lock is set, and the status byte is 80h.
- R2: A bus write is taken when the combined strobe (`ce_n` and `we_n` both low) ends, whichever pin rises first. Address and data come from the last clock in which both were low. One strobe gives exactly one command.
- R3: 40h followed by a data strobe programs that byte as old AND data. It takes PROG_CYCLES cycles with `rdy` low, and reads return status afterwards.
- R4: 20h followed by D0h, both addressed inside a block, sets every byte of that block to FFh and leaves other blocks unchanged. A second byte other than D0h sets status bits 5 and 4 and starts nothing.
- R5: FFh selects array reads and 70h selects status reads. The status bits are: 7 ready, 6 erase suspended, 5 erase/clear error, 4 program/set error, 2 program suspended, 1 lock error. Bits 3 and 0 read 0.
- R6: B0h during an erase suspends it: status bits 7 and 6 go to 1, `rdy` goes high and the array stops changing. D0h resumes it and clears bits 6 and 7 until the erase completes.
- R7: While an erase is suspended, a byte program to another block runs normally. A program to the suspended block sets bit 4 and leaves the array unchanged. B0h during that program sets bit 2. The first D0h resumes the program and a second D0h resumes the erase.
- R8: While any operation is suspended, 20h and 60h are ignored and leave no pending command.
- R9: 60h followed by 01h locks the addressed block. An erase or program to a locked block sets bit 1 together with bit 5 (erase) or bit 4 (program) and leaves the array unchanged.
- R10: 60h followed by D0h clears all block locks. 60h followed by F1h sets the master lock, which stays set until reset. While it is set, a block lock set fails with bits 4 and 1 and a clear fails with bits 5 and 1, and the block locks do not change.
- R11: Error bits 5, 4 and 1 stay set until a 50h command clears them.
- R12: While an operation runs, every written byte except B0h and 70h is ignored.
- R13: `dout` is 00h and `dq_oe` is 0 unless `ce_n` and `oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the block |
| din | input | 8 | Write data or command byte |
| dout | output | 8 | Array byte or status byte |
| dq_oe | output | 1 | High when `dout` is driven onto the bus |
| rdy | output | 1 | High when no operation is running |

## Verification
The assertions assume that every write strobe lasts at least one full clock with both `ce_n` and `we_n` low. They also assume a gap of at least one clock with the strobe high before the next strobe starts, because the decoder sees one command per falling edge of the combined strobe. The bench drives each strobe for one clock and then keeps it high for two clocks, and it changes the address and data only at falling clock edges. The timed checks (suspend during an erase sweep, suspend during a program) depend on the default durations being longer than the three-clock gap between bus writes. The bench runs with those defaults.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_PROG     = 8'h40;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_CLRSTAT  = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_LOCK_BLK = 8'h01;
    localparam logic [7:0] OP_LOCK_MST = 8'hF1;
    localparam logic [7:0] OP_READ     = 8'hFF;

    typedef enum logic {RD_ARRAY, RD_STATUS} rd_mode_e;
    typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG, PD_LOCK} pend_e;
    typedef enum logic [1:0] {W_IDLE, W_ERASE, W_PROG, W_LOCK} wsm_e;
    typedef enum logic [1:0] {LK_BLK, LK_MST, LK_CLR} lock_op_e;
    typedef enum logic [1:0] {ARR_NONE, ARR_ERASE, ARR_PROG} arr_op_e;

    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic erase_err;
        logic prog_err;
        logic volt_err;
        logic prog_susp;
        logic lock_err;
        logic rsvd;
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        return s;
    endfunction
endpackage

// File: rtl/fcsm_bus_sync.sv
module fcsm_bus_sync #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              cmd_vld,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);
    logic strobe, strobe_q;
    assign strobe = ~ce_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            cmd_vld  <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            strobe_q <= strobe;
            cmd_vld  <= strobe_q & ~strobe;
            if (strobe) begin
                cmd_addr <= addr;
                cmd_data <= din;
            end
        end
    end

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |=> !cmd_vld);
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array
    import fcsm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  arr_op_e           op,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        case (op)
            ARR_ERASE: mem[waddr] <= 8'hFF;
            ARR_PROG:  mem[waddr] <= mem[waddr] & wdata;
            default:   ;
        endcase
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fcsm_locks.sv
module fcsm_locks #(
    parameter int NUM_BLOCKS = 32,
    parameter int BLK_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_blk,
    input  logic                  set_mst,
    input  logic                  clr_blk,
    input  logic [BLK_W-1:0]      blk_sel,
    output logic [NUM_BLOCKS-1:0] blk_locked,
    output logic                  mst_locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_locked <= '0;
            mst_locked <= 1'b0;
        end else begin
            if (clr_blk)
                blk_locked <= '0;
            else if (set_blk)
                blk_locked[blk_sel] <= 1'b1;
            if (set_mst)
                mst_locked <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_cui.sv
module flash_cui
    import fcsm_pkg::*;
#(
    parameter int NUM_BLOCKS  = 32,
    parameter int BLOCK_BYTES = 32,
    parameter int PROG_CYCLES = 16,
    parameter int LOCK_CYCLES = 6,
    parameter int ADDR_W      = $clog2(NUM_BLOCKS) + $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dq_oe,
    output logic              rdy
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int CMAX  = (PROG_CYCLES > LOCK_CYCLES) ? PROG_CYCLES : LOCK_CYCLES;
    localparam int CNT_W = $clog2(CMAX + 1);

    logic              cmd_vld;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic [BLK_W-1:0]  cmd_blk;

    rd_mode_e  rd_mode;
    pend_e     pend;
    wsm_e      wsm;
    lock_op_e  l_op;
    arr_op_e   arr_op;
    logic [ADDR_W-1:0] arr_waddr;

    logic              esusp, wsusp;
    logic [BLK_W-1:0]  e_blk, l_blk;
    logic [OFF_W-1:0]  e_idx;
    logic [ADDR_W-1:0] p_addr;
    logic [7:0]        p_data;
    logic [CNT_W-1:0]  p_cnt;
    logic              err_e, err_w, err_l;

    logic [NUM_BLOCKS-1:0] lock_vec;
    logic                  mst_locked;
    logic                  lk_set_blk, lk_set_mst, lk_clr;
    logic [7:0]            arr_rdata;
    status_t               stat;
    logic                  erase_last, prog_last, lock_last, suspended;

    fcsm_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    fcsm_locks #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_locks (
        .clk(clk), .rst(rst), .set_blk(lk_set_blk), .set_mst(lk_set_mst),
        .clr_blk(lk_clr), .blk_sel(l_blk), .blk_locked(lock_vec), .mst_locked(mst_locked)
    );

    fcsm_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .op(arr_op), .waddr(arr_waddr), .wdata(p_data),
        .raddr(addr), .rdata(arr_rdata)
    );

    assign cmd_blk    = cmd_addr[ADDR_W-1:OFF_W];
    assign suspended  = esusp | wsusp;
    assign erase_last = (wsm == W_ERASE) && (e_idx == OFF_W'(BLOCK_BYTES - 1));
    assign prog_last  = (wsm == W_PROG) && (p_cnt == '0);
    assign lock_last  = (wsm == W_LOCK) && (p_cnt == '0);
    assign rdy        = (wsm == W_IDLE);

    always_comb begin
        arr_op    = ARR_NONE;
        arr_waddr = p_addr;
        if (wsm == W_ERASE) begin
            arr_op    = ARR_ERASE;
            arr_waddr = {e_blk, e_idx};
        end else if (prog_last) begin
            arr_op    = ARR_PROG;
        end
    end

    assign lk_set_blk = lock_last && (l_op == LK_BLK);
    assign lk_set_mst = lock_last && (l_op == LK_MST);
    assign lk_clr     = lock_last && (l_op == LK_CLR);

    always_comb begin
        stat            = '0;
        stat.ready      = rdy;
        stat.erase_susp = esusp;
        stat.erase_err  = err_e;
        stat.prog_err   = err_w;
        stat.prog_susp  = wsusp;
        stat.lock_err   = err_l;
    end

    assign dq_oe = ~ce_n & ~oe_n;
    assign dout  = !dq_oe ? 8'h00 :
                   (rd_mode == RD_ARRAY) ? arr_rdata : status_byte(stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mode <= RD_ARRAY;
            pend    <= PD_NONE;
            wsm     <= W_IDLE;
            l_op    <= LK_BLK;
            esusp   <= 1'b0;
            wsusp   <= 1'b0;
            e_blk   <= '0;
            l_blk   <= '0;
            e_idx   <= '0;
            p_addr  <= '0;
            p_data  <= '0;
            p_cnt   <= '0;
            err_e   <= 1'b0;
            err_w   <= 1'b0;
            err_l   <= 1'b0;
        end else begin
            // operation progress
            case (wsm)
                W_ERASE: begin
                    e_idx <= e_idx + 1'b1;
                    if (erase_last) wsm <= W_IDLE;
                end
                W_PROG, W_LOCK: begin
                    if (p_cnt == '0) wsm <= W_IDLE;
                    else             p_cnt <= p_cnt - 1'b1;
                end
                default: ;
            endcase

            if (cmd_vld) begin
                if (wsm != W_IDLE) begin
                    // only suspend and status are honoured while running
                    if (cmd_data == OP_STATUS) begin
                        rd_mode <= RD_STATUS;
                    end else if (cmd_data == OP_SUSPEND) begin
                        rd_mode <= RD_STATUS;
                        if (wsm == W_ERASE && !erase_last) begin
                            wsm   <= W_IDLE;
                            esusp <= 1'b1;
                        end else if (wsm == W_PROG && !prog_last) begin
                            wsm   <= W_IDLE;
                            wsusp <= 1'b1;
                        end
                    end
                end else if (pend != PD_NONE) begin
                    pend    <= PD_NONE;
                    rd_mode <= RD_STATUS;
                    case (pend)
                        PD_ERASE: begin
                            if (cmd_data != OP_CONFIRM) begin
                                err_e <= 1'b1;
                                err_w <= 1'b1;
                            end else if (lock_vec[cmd_blk]) begin
                                err_e <= 1'b1;
                                err_l <= 1'b1;
                            end else begin
                                e_blk <= cmd_blk;
                                e_idx <= '0;
                                wsm   <= W_ERASE;
                            end
                        end
                        PD_PROG: begin
                            if (lock_vec[cmd_blk]) begin
                                err_w <= 1'b1;
                                err_l <= 1'b1;
                            end else if (esusp && cmd_blk == e_blk) begin
                                err_w <= 1'b1;
                            end else begin
                                p_addr <= cmd_addr;
                                p_data <= cmd_data;
                                p_cnt  <= CNT_W'(PROG_CYCLES - 1);
                                wsm    <= W_PROG;
                            end
                        end
                        default: begin
                            l_blk <= cmd_blk;
                            p_cnt <= CNT_W'(LOCK_CYCLES - 1);
                            if (cmd_data == OP_LOCK_MST) begin
                                l_op <= LK_MST;
                                wsm  <= W_LOCK;
                            end else if (cmd_data == OP_LOCK_BLK) begin
                                if (mst_locked) begin
                                    err_w <= 1'b1;
                                    err_l <= 1'b1;
                                end else begin
                                    l_op <= LK_BLK;
                                    wsm  <= W_LOCK;
                                end
                            end else if (cmd_data == OP_CONFIRM) begin
                                if (mst_locked) begin
                                    err_e <= 1'b1;
                                    err_l <= 1'b1;
                                end else begin
                                    l_op <= LK_CLR;
                                    wsm  <= W_LOCK;
                                end
                            end else begin
                                err_e <= 1'b1;
                                err_w <= 1'b1;
                            end
                        end
                    endcase
                end else begin
                    case (cmd_data)
                        OP_READ:    rd_mode <= RD_ARRAY;
                        OP_STATUS:  rd_mode <= RD_STATUS;
                        OP_CLRSTAT: begin
                            err_e <= 1'b0;
                            err_w <= 1'b0;
                            err_l <= 1'b0;
                        end
                        OP_CONFIRM: begin
                            if (wsusp) begin
                                wsusp   <= 1'b0;
                                wsm     <= W_PROG;
                                rd_mode <= RD_STATUS;
                            end else if (esusp) begin
                                esusp   <= 1'b0;
                                wsm     <= W_ERASE;
                                rd_mode <= RD_STATUS;
                            end
                        end
                        OP_PROG: begin
                            if (!wsusp) begin
                                pend    <= PD_PROG;
                                rd_mode <= RD_STATUS;
                            end
                        end
                        OP_ERASE: begin
                            if (!suspended) begin
                                pend    <= PD_ERASE;
                                rd_mode <= RD_STATUS;
                            end
                        end
                        OP_LOCK: begin
                            if (!suspended) begin
                                pend    <= PD_LOCK;
                                rd_mode <= RD_STATUS;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    p_erase_susp_ready_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(esusp) |-> rdy);
    p_prog_susp_ready_r7: assert property (@(posedge clk) disable iff (rst)
        wsusp |-> rdy);
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (err_e && !(cmd_vld && cmd_data == OP_CLRSTAT)) |=> err_e);
    p_lock_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (err_l && !(cmd_vld && cmd_data == OP_CLRSTAT)) |=> err_l);
    p_locks_only_grow_r10: assert property (@(posedge clk) disable iff (rst)
        !lk_clr |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));
    p_master_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        mst_locked |=> mst_locked);
    p_master_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        mst_locked |-> !(lk_set_blk || lk_clr));
endmodule

// File: tb/flash_cui_bench.sv
module flash_cui_bench;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dq_oe, rdy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_cui u_flash_cui (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe), .rdy(rdy)
    );

    localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_P = 2'd2;
    typedef struct packed {
        logic [1:0]    k;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [7:0]    e;
        logic [3:0]    r;
    } vec_t;

    // rows tagged R4 (erase), R3 (program), R11 (clear), R5 (modes)
    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        '{K_W, 10'h020, 8'h20, 8'h00, 4'd4}, '{K_W, 10'h020, 8'hD0, 8'h00, 4'd4},
        '{K_P, 10'h000, 8'h00, 8'h80, 4'd4},
        '{K_W, 10'h040, 8'h20, 8'h00, 4'd4}, '{K_W, 10'h041, 8'hD0, 8'h00, 4'd4},
        '{K_P, 10'h000, 8'h00, 8'h80, 4'd4},
        '{K_W, 10'h000, 8'h20, 8'h00, 4'd4}, '{K_W, 10'h000, 8'hD0, 8'h00, 4'd4},
        '{K_P, 10'h000, 8'h00, 8'h80, 4'd4},
        '{K_W, 10'h000, 8'hFF, 8'h00, 4'd5}, '{K_R, 10'h020, 8'h00, 8'hFF, 4'd4},
        '{K_W, 10'h025, 8'h40, 8'h00, 4'd3}, '{K_W, 10'h025, 8'hA5, 8'h00, 4'd3},
        '{K_P, 10'h000, 8'h00, 8'h80, 4'd3},
        '{K_W, 10'h000, 8'hFF, 8'h00, 4'd3}, '{K_R, 10'h025, 8'h00, 8'hA5, 4'd3},
        '{K_W, 10'h025, 8'h40, 8'h00, 4'd3}, '{K_W, 10'h025, 8'h3C, 8'h00, 4'd3},
        '{K_P, 10'h000, 8'h00, 8'h80, 4'd3},
        '{K_W, 10'h000, 8'hFF, 8'h00, 4'd3}, '{K_R, 10'h025, 8'h00, 8'h24, 4'd3},
        '{K_R, 10'h024, 8'h00, 8'hFF, 4'd4},
        '{K_W, 10'h021, 8'h20, 8'h00, 4'd4}, '{K_W, 10'h021, 8'h77, 8'h00, 4'd4},
        '{K_R, 10'h000, 8'h00, 8'hB0, 4'd4},
        '{K_W, 10'h000, 8'h50, 8'h00, 4'd11}, '{K_R, 10'h000, 8'h00, 8'h80, 4'd11}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #2 d = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic poll(output logic [7:0] st);
        st = 8'h00;
        for (int i = 0; i < 400; i++) begin
            bus_rd('0, st);
            if (st[7]) break;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy", {7'd0, rdy}, 8'h01);
        bus_wr('0, 8'h70);
        bus_rd('0, v);  check("R1 status", v, 8'h80);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VT[i].r, i);
            case (VT[i].k)
                K_W: bus_wr(VT[i].a, VT[i].d);
                K_R: begin bus_rd(VT[i].a, v); check(tag, v, VT[i].e); end
                default: begin poll(v); check(tag, v, VT[i].e); end
            endcase
        end

        // R13 output gating
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1;
        #2 check("R13 dout", dout, 8'h00);
        check("R13 dq_oe", {7'd0, dq_oe}, 8'h00);
        ce_n = 1'b1;

        // R12 commands ignored while erase runs
        bus_wr(10'h040, 8'h20); bus_wr(10'h040, 8'hD0);
        check("R12 busy", {7'd0, rdy}, 8'h00);
        bus_wr(10'h040, 8'h20);
        poll(v);
        bus_wr('0, 8'hFF); bus_wr('0, 8'h70);
        bus_rd('0, v);  check("R12 no pending", v, 8'h80);

        // R6 erase suspend / resume
        bus_wr(10'h03F, 8'h40); bus_wr(10'h03F, 8'h00); poll(v);
        bus_wr(10'h020, 8'h20); bus_wr(10'h020, 8'hD0);
        bus_wr(10'h020, 8'hB0);
        bus_rd('0, v);  check("R6 suspended status", v, 8'hC0);
        check("R6 rdy", {7'd0, rdy}, 8'h01);
        bus_wr('0, 8'hFF);
        bus_rd(10'h03F, v); check("R6 untouched", v, 8'h00);
        repeat (60) @(negedge clk);
        bus_rd(10'h03F, v); check("R6 frozen", v, 8'h00);

        // R7 program into suspended block refused
        bus_wr(10'h030, 8'h40); bus_wr(10'h030, 8'h00);
        bus_rd('0, v);  check("R7 same block", v, 8'hD0);
        bus_wr('0, 8'h50);
        bus_rd('0, v);  check("R11 cleared", v, 8'hC0);

        // R8 lock setup ignored while suspended
        bus_wr('0, 8'h60); bus_wr('0, 8'h70);
        bus_rd('0, v);  check("R8 ignored", v, 8'hC0);

        // R7 nested program suspend
        bus_wr(10'h045, 8'h40); bus_wr(10'h045, 8'h5A);
        bus_wr('0, 8'hB0);
        bus_rd('0, v);  check("R7 nested status", v, 8'hC4);
        bus_wr('0, 8'hFF);
        bus_rd(10'h045, v); check("R7 not yet written", v, 8'hFF);
        bus_wr('0, 8'hD0);
        bus_rd('0, v);  check("R7 program resumed", v, 8'h40);
        poll(v);        check("R7 program done", v, 8'hC0);
        bus_wr('0, 8'hFF);
        bus_rd(10'h045, v); check("R7 programmed", v, 8'h5A);
        bus_wr('0, 8'hD0);
        bus_rd('0, v);  check("R6 resume clears 7/6", v, 8'h00);
        poll(v);        check("R6 erase done", v, 8'h80);
        bus_wr('0, 8'hFF);
        bus_rd(10'h03F, v); check("R6 erased", v, 8'hFF);

        // R9 block lock
        bus_wr(10'h040, 8'h60); bus_wr(10'h040, 8'h01); poll(v);
        check("R9 lock set", v, 8'h80);
        bus_wr(10'h041, 8'h40); bus_wr(10'h041, 8'h00);
        bus_rd('0, v);  check("R9 program locked", v, 8'h92);
        bus_wr('0, 8'h50);
        bus_wr(10'h040, 8'h20); bus_wr(10'h040, 8'hD0);
        bus_rd('0, v);  check("R9 erase locked", v, 8'hA2);
        bus_wr('0, 8'hFF);
        bus_rd(10'h045, v); check("R9 array kept", v, 8'h5A);
        bus_wr('0, 8'h50);

        // R10 clear locks, then master lock
        bus_wr('0, 8'h60); bus_wr('0, 8'hD0); poll(v);
        bus_wr(10'h041, 8'h40); bus_wr(10'h041, 8'h0F); poll(v);
        check("R10 unlocked write", v, 8'h80);
        bus_wr('0, 8'hFF);
        bus_rd(10'h041, v); check("R10 data", v, 8'h0F);
        bus_wr('0, 8'h60); bus_wr('0, 8'hF1); poll(v);
        bus_wr('0, 8'h60); bus_wr('0, 8'h01);
        bus_rd('0, v);  check("R10 set refused", v, 8'h92);
        bus_wr('0, 8'h60); bus_wr('0, 8'hD0);
        bus_rd('0, v);  check("R10 clear refused", v, 8'hB2);
        bus_wr('0, 8'h50);
        bus_wr(10'h001, 8'h40); bus_wr(10'h001, 8'h11); poll(v);
        check("R10 block0 still open", v, 8'h80);

        // R2 CE-controlled strobe, data from last low cycle
        @(negedge clk);
        addr = '0; din = 8'h70; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); din = 8'hFF;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_rd(10'h045, v); check("R2 last data", v, 8'h5A);

        // R1 reset returns array mode
        bus_wr('0, 8'h70);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_rd(10'h001, v); check("R1 array mode", v, 8'h11);
        bus_wr('0, 8'h70);
        bus_rd('0, v);  check("R1 status", v, 8'h80);

        summary();
    end
endmodule